// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block watches the transmit error count of a CAN protocol controller and takes the node off the bus when that count passes its limit. On entry it raises its own init flag and a bus-off flag. It then waits for the host to release init. Once init is released, it counts runs of eleven consecutive recessive bits, taking one bit on each bit-time strobe. After the 129th run it pulses a clear to the error counters and the node returns to normal operation.

While recovery is running, the count of completed runs is shown on the receive error count output. Each completed run also writes the Bit0 code into the last-error-code field. Software can use these to tell a bus that is stuck dominant from one that is slowly recovering. If the host writes init back to 1 during recovery, counting pauses. Nothing the host writes can complete the sequence early or skip any part of it.

Top module: `busOffRecovery`

## Requirements
- R1: Bus-off is entered when `txErrCount` is greater than 255. The flags show it one clock after the count is sampled. A value of exactly 255 causes no entry.
- R2: On entering bus-off, `busOffFlag` and `initFlag` both go to 1 in the same cycle.
- R3: While bus-off is active and `initFlag` is 1, bit strobes make no progress and `recCount` holds its value. A host write of 1 in that state changes nothing.
- R4: Each completed run of 11 recessive bits writes `lastErrCode` with the Bit0 code. The field is 3 bits wide and the Bit0 code is 5.
- R5: During recovery, `recCount` equals the number of completed runs. It steps by one in the cycle after the strobe that carries the 11th recessive bit. `rxBit` = 1 means recessive.
- R6: A dominant bit (`rxBit` = 0) sampled during recovery sets the current run length back to zero. Completed runs are kept.
- R7: After a run completes, the run length restarts at zero, so the next run needs 11 new recessive bits.
- R8: The strobe that completes run 129 clears `busOffFlag` and raises `errCntClear` in the same cycle. `errCntClear` is high for exactly one cycle, and `recCount` returns to 0.
- R9: A host write of init = 1 during recovery sets `initFlag` and pauses counting. Both the completed runs and the current partial run are kept. Writing 0 resumes counting. Recovery never completes before 129 runs.
- R10: Bits are taken only on cycles where `bitStrobe` is 1. A dominant level without a strobe has no effect.
- R11: Outside bus-off, a host write sets `initFlag` to the written value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One-cycle pulse marking a sampled bit |
| rxBit | input | 1 | Sampled bus level, 1 = recessive |
| txErrCount | input | 9 | Transmit error counter value |
| hostInitWrEn | input | 1 | Host write strobe for the init bit |
| hostInitWrData | input | 1 | Value written to the init bit |
| initFlag | output | 1 | Init status |
| busOffFlag | output | 1 | Bus-off status |
| lastErrCode | output | 3 | Last error code, 5 = Bit0 |
| recCount | output | 8 | Completed recessive runs during recovery |
| errCntClear | output | 1 | One-cycle pulse that resets the error counters |

## Verification
Every output is a register, so each result is due one clock after the edge that samples its stimulus. That stimulus can be a strobe with its bit, a host write, or a new error count. The bench drives inputs on the falling edge and releases them on the next falling edge. It reads the outputs at that second falling edge, which falls half a period after the edge where they change. The completion pulse lasts one cycle, so it is read in that same window and read again one cycle later to confirm it has dropped. A falling-edge counter confirms that only one pulse occurs in the whole run.

// File: rtl/busOffPkg.sv
package busOffPkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_HELD    = 2'd1,
    ST_RECOVER = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clearAll;  // wipe run and sequence counters on bus-off entry
    logic countEn;   // take rxBit this cycle
  } dpCtrl_t;

  localparam int LEC_W = 3;
  localparam logic [LEC_W-1:0] LEC_BIT0 = 3'd5;
endpackage

// File: rtl/busOffDatapath.sv
module busOffDatapath
  import busOffPkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 129,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic             rxBit,
  output logic             seqDone,
  output logic [CNT_W-1:0] recCount,
  output logic [LEC_W-1:0] lastErrCode
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RUN_COUNT - 1);

  logic [RUN_W-1:0] runCnt;
  logic             runDone;

  assign runDone = ctrl.countEn & rxBit & (runCnt == RUN_LAST);
  assign seqDone = runDone & (recCount == REC_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt      <= '0;
      recCount    <= '0;
      lastErrCode <= '0;
    end else if (ctrl.clearAll) begin
      runCnt   <= '0;
      recCount <= '0;
    end else if (ctrl.countEn) begin
      if (!rxBit) begin
        runCnt <= '0;
      end else if (runDone) begin
        runCnt      <= '0;
        lastErrCode <= LEC_BIT0;
        if (seqDone) recCount <= '0;
        else         recCount <= recCount + 1'b1;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/busOffControl.sv
module busOffControl
  import busOffPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitStrobe,
  input  logic    tecOver,
  input  logic    hostWrEn,
  input  logic    hostWrData,
  input  logic    seqDone,
  output dpCtrl_t ctrl,
  output logic    initFlag,
  output logic    busOffFlag,
  output logic    errCntClear
);
  seqState_t state;

  always_comb begin
    ctrl.countEn  = (state == ST_RECOVER) && bitStrobe;
    ctrl.clearAll = (state == ST_ACTIVE) && tecOver;
  end

  assign busOffFlag = (state != ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_ACTIVE;
      initFlag    <= 1'b0;
      errCntClear <= 1'b0;
    end else begin
      errCntClear <= 1'b0;
      case (state)
        ST_ACTIVE: begin
          if (tecOver) begin
            state    <= ST_HELD;
            initFlag <= 1'b1;
          end else if (hostWrEn) begin
            initFlag <= hostWrData;
          end
        end
        ST_HELD: begin
          if (hostWrEn && !hostWrData) begin
            state    <= ST_RECOVER;
            initFlag <= 1'b0;
          end
        end
        ST_RECOVER: begin
          if (seqDone) begin
            state       <= ST_ACTIVE;
            errCntClear <= 1'b1;
          end else if (hostWrEn && hostWrData) begin
            state    <= ST_HELD;
            initFlag <= 1'b1;
          end
        end
        default: state <= ST_ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/busOffRecovery.sv
module busOffRecovery
  import busOffPkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 129,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             rxBit,
  input  logic [TEC_W-1:0] txErrCount,
  input  logic             hostInitWrEn,
  input  logic             hostInitWrData,
  output logic             initFlag,
  output logic             busOffFlag,
  output logic [2:0]       lastErrCode,
  output logic [CNT_W-1:0] recCount,
  output logic             errCntClear
);
  dpCtrl_t ctrl;
  logic    seqDone;
  logic    tecOver;

  assign tecOver = (txErrCount > TEC_W'(TEC_LIMIT));

  busOffControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitStrobe  (bitStrobe),
    .tecOver    (tecOver),
    .hostWrEn   (hostInitWrEn),
    .hostWrData (hostInitWrData),
    .seqDone    (seqDone),
    .ctrl       (ctrl),
    .initFlag   (initFlag),
    .busOffFlag (busOffFlag),
    .errCntClear(errCntClear)
  );

  busOffDatapath #(
    .RUN_LEN  (RUN_LEN),
    .RUN_COUNT(RUN_COUNT),
    .CNT_W    (CNT_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .rxBit      (rxBit),
    .seqDone    (seqDone),
    .recCount   (recCount),
    .lastErrCode(lastErrCode)
  );
endmodule

// File: rtl/busOffRecoveryChecker.sv
module busOffRecoveryChecker #(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [TEC_W-1:0] txErrCount,
  input logic             initFlag,
  input logic             busOffFlag,
  input logic [2:0]       lastErrCode,
  input logic [CNT_W-1:0] recCount,
  input logic             errCntClear
);
  assert_entry_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOffFlag) |-> ($past(txErrCount) > TEC_W'(TEC_LIMIT)));

  assert_entry_sets_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOffFlag) |-> initFlag);

  assert_hold_while_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    (initFlag && busOffFlag) |=> (recCount == $past(recCount)));

  assert_lec_on_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busOffFlag && (recCount != $past(recCount))) |-> (lastErrCode == 3'd5));

  assert_rec_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busOffFlag && $past(busOffFlag)) |->
      ((recCount == $past(recCount)) || (recCount == $past(recCount) + 1'b1)));

  assert_clear_with_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    errCntClear |-> $fell(busOffFlag));

  assert_clear_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    errCntClear |=> !errCntClear);
endmodule

bind busOffRecovery busOffRecoveryChecker #(
  .TEC_W    (TEC_W),
  .TEC_LIMIT(TEC_LIMIT),
  .CNT_W    (CNT_W)
) uChk (.*);

// File: tb/sim_busOffRecovery.sv
module sim_busOffRecovery;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       rxBit = 1'b1;
  logic [8:0] txErrCount = '0;
  logic       hostInitWrEn = 1'b0;
  logic       hostInitWrData = 1'b0;
  logic       initFlag, busOffFlag, errCntClear;
  logic [2:0] lastErrCode;
  logic [7:0] recCount;

  int checks = 0;
  int failures = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  busOffRecovery u0 (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxBit(rxBit),
    .txErrCount(txErrCount), .hostInitWrEn(hostInitWrEn),
    .hostInitWrData(hostInitWrData), .initFlag(initFlag),
    .busOffFlag(busOffFlag), .lastErrCode(lastErrCode),
    .recCount(recCount), .errCntClear(errCntClear)
  );

  always @(negedge clk) if (rstN && errCntClear) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitStrobe = 1'b1; rxBit = b;
    @(negedge clk); bitStrobe = 1'b0; rxBit = 1'b1;
  endtask

  task automatic sendRun(input int n, input logic b);
    for (int i = 0; i < n; i++) sendBit(b);
  endtask

  task automatic hostWrite(input logic d);
    @(negedge clk); hostInitWrEn = 1'b1; hostInitWrData = d;
    @(negedge clk); hostInitWrEn = 1'b0;
  endtask

  task automatic setTec(input int v);
    @(negedge clk); txErrCount = 9'(v);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset initFlag", int'(initFlag), 0);
    chk("reset busOffFlag", int'(busOffFlag), 0);
    chk("reset lastErrCode", int'(lastErrCode), 0);
    chk("reset recCount", int'(recCount), 0);
    chk("reset errCntClear", int'(errCntClear), 0);

    hostWrite(1'b1); chk("R11 host set init", int'(initFlag), 1);
    hostWrite(1'b0); chk("R11 host clear init", int'(initFlag), 0);

    setTec(255); chk("R1 limit 255 no entry", int'(busOffFlag), 0);
    setTec(256);
    chk("R1 entry at 256", int'(busOffFlag), 1);
    chk("R2 init set on entry", int'(initFlag), 1);
    setTec(0);

    sendRun(30, 1'b1); chk("R3 no progress while init", int'(recCount), 0);
    hostWrite(1'b1);
    chk("R3 write 1 held init", int'(initFlag), 1);
    chk("R3 write 1 held busoff", int'(busOffFlag), 1);
    hostWrite(1'b0); chk("R9 release init", int'(initFlag), 0);

    sendRun(10, 1'b1); chk("R5 10 bits no run", int'(recCount), 0);
    sendBit(1'b1);
    chk("R5 first run", int'(recCount), 1);
    chk("R4 bit0 code", int'(lastErrCode), 5);

    sendRun(5, 1'b1); sendBit(1'b0); sendRun(10, 1'b1);
    chk("R6 dominant restarts run", int'(recCount), 1);
    sendBit(1'b1); chk("R6 run after dominant", int'(recCount), 2);

    sendRun(10, 1'b1); chk("R7 fresh run needs 11", int'(recCount), 2);
    sendBit(1'b1); chk("R7 run completes", int'(recCount), 3);

    sendRun(5, 1'b1);
    @(negedge clk); rxBit = 1'b0;
    repeat (4) @(negedge clk);
    rxBit = 1'b1;
    sendRun(6, 1'b1); chk("R10 unstrobed dominant ignored", int'(recCount), 4);

    sendRun(5, 1'b1);
    hostWrite(1'b1); chk("R9 pause sets init", int'(initFlag), 1);
    sendRun(20, 1'b0); sendRun(20, 1'b1);
    chk("R9 paused no progress", int'(recCount), 4);
    hostWrite(1'b0);
    sendRun(6, 1'b1); chk("R9 partial run kept", int'(recCount), 5);
    chk("R9 still bus-off", int'(busOffFlag), 1);

    for (int run = 5; run < 128; run++) begin
      sendRun(11, 1'b1);
      chk("R5 sweep recCount", int'(recCount), run + 1);
    end
    chk("R9 not shortened busoff", int'(busOffFlag), 1);
    chk("R9 no early clear", pulses, 0);

    sendRun(10, 1'b1); chk("R8 one bit short", int'(busOffFlag), 1);
    sendBit(1'b1);
    chk("R8 busoff cleared", int'(busOffFlag), 0);
    chk("R8 clear pulse", int'(errCntClear), 1);
    chk("R8 recCount zero", int'(recCount), 0);
    chk("R8 init stays clear", int'(initFlag), 0);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(errCntClear), 0);
    chk("R8 single pulse", pulses, 1);

    hostWrite(1'b1); chk("R11 normal set init", int'(initFlag), 1);
    chk("R11 no busoff", int'(busOffFlag), 0);

    summary();
    $finish;
  end
endmodule